// File: doc/BRIEF.md
# Flash Read-Protection Access Filter

This block sits in front of an on-chip program flash and rules on every read that reaches it. Each request is either an instruction fetch or a data read, and it carries a tag that names the requesting master: the CPU, the DMA engine or the peripheral processor. The block registers its decision and returns it one cycle later, through a valid/ready handshake, as either a grant or a bus-error response. The flash array itself is not part of the block.

Protection is installed outside the block, and that fact arrives here as a single level input. While protection is installed, software can suspend it by writing two 32-bit keywords in sequence. A status output reads 1 while protection is installed but suspended. A resume command turns protection back on. While protection is active, the block also limits software in two ways. Software may not clear the per-master disable bits in the control register. The cache/scratchpad configuration register accepts only a single write after reset.

The start mode is also an input. It sets the reset value of the fetch-disable and data-disable bits. The stored keywords are modelled as inputs as well.

Top module: `flash_guard`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `suspended` is 0. The per-master bits `ctl_q[2]` (DMA) and `ctl_q[3]` (peripheral processor) are 0. When `boot_internal`=0, the fetch-disable bit `ctl_q[0]` and the data-disable bit `ctl_q[1]` both reset to the value of `prot_installed`.
- R2: While protection is active, meaning installed and not suspended, the following holds. A fetch (`req_fetch`=1) returns an error when `ctl_q[0]`=1. A data read (`req_fetch`=0) returns an error when `ctl_q[1]`=1. With only `ctl_q[1]` set, fetches are granted.
- R3: While protection is not installed, or is suspended, `ctl_q[0]` and `ctl_q[1]` have no effect, and CPU accesses are granted.
- R4: A data read tagged DMA (`req_tag`=1) is refused when `ctl_q[2]`=1. A data read tagged peripheral processor (`req_tag`=2) is refused when `ctl_q[3]`=1. Both rules apply whether or not protection is active. A CPU data read (`req_tag`=0) is not affected by either bit.
- R5: While protection is active, a control write that would clear `ctl_q[2]` or `ctl_q[3]` leaves that bit set, while setting either bit takes effect. While protection is suspended or not installed, the write takes effect in full.
- R6: The write sequence on `pw_valid`/`pw_data` works as follows. A write equal to `key_a` followed directly by a write equal to `key_b` sets `suspended` to 1. Any non-matching write aborts the sequence, and `suspended` then stays 0.
- R7: `resume` clears `suspended`. The control bits keep the values they held when `resume` arrived.
- R8: While protection is active, `cfg_q` accepts only the first write after reset and ignores later writes. While protection is suspended or not installed, every write is accepted.
- R9: A request accepted on `req_valid && req_ready` produces `rsp_valid` on the next cycle, with `rsp_grant` = !`rsp_err`. The response holds steady until `rsp_ready` is 1. `req_ready` is 0 while an unconsumed response is held.
- R10: When `boot_internal`=1, `ctl_q[0]` and `ctl_q[1]` reset to 0, even when protection is installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_internal | input | 1 | Start mode: 1 = internal start from flash |
| prot_installed | input | 1 | Read protection installed |
| key_a | input | 32 | First stored keyword |
| key_b | input | 32 | Second stored keyword |
| pw_valid | input | 1 | Password write strobe |
| pw_data | input | 32 | Password write data |
| resume | input | 1 | Re-enable protection |
| suspended | output | 1 | Protection installed but suspended |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data: [0] fetch dis, [1] data dis, [2] DMA data dis, [3] PP data dis |
| ctl_q | output | 4 | Control register contents |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_q | output | CFG_W | Configuration register contents |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| req_tag | input | 2 | Master tag: 0 CPU, 1 DMA, 2 peripheral processor |
| rsp_valid | output | 1 | Decision available |
| rsp_ready | input | 1 | Requester takes the decision |
| rsp_grant | output | 1 | Access may proceed |
| rsp_err | output | 1 | Access answered with bus error |

## Verification
Each kind of access is tried under three protection states: active, suspended by password, and not installed. The fetch/data split and the per-master bits are tried in every combination. Together these separate the protection-gated disable bits from the per-master bits, which are always enforced. Control writes that try to clear, and writes that try to set, are compared in the active and the suspended state, which shows that clearing is refused only while protection is active. A wrong keyword, a keyword out of order and a correct pair show the abort and restart rules of the unlock sequence. A response held with `rsp_ready` low shows that the decision stays stable and that the block applies backpressure.

// File: rtl/fg_pkg.sv
package fg_pkg;

    typedef enum logic [1:0] {
        TAG_CPU = 2'd0,
        TAG_DMA = 2'd1,
        TAG_PP  = 2'd2,
        TAG_RSV = 2'd3
    } tag_e;

    // Control register layout; bit positions are software-visible
    typedef struct packed {
        logic pp_dis;     // [3]
        logic dma_dis;    // [2]
        logic data_dis;   // [1]
        logic fetch_dis;  // [0]
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

endpackage

// File: rtl/fg_ctl_reg.sv
module fg_ctl_reg
    import fg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_internal,
    input  logic prot_installed,
    input  logic prot_active,
    input  logic we,
    input  ctl_t wdata,
    output ctl_t ctl_q
);

    typedef struct packed {
        ctl_t ctl;
    } st_t;

    st_t st_d, st_q;
    logic rst_dis;

    assign rst_dis = prot_installed & ~boot_internal;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ctl.fetch_dis = wdata.fetch_dis;
            st_d.ctl.data_dis  = wdata.data_dis;
            if (prot_active) begin
                // clearing is refused, setting is honoured
                st_d.ctl.dma_dis = st_q.ctl.dma_dis | wdata.dma_dis;
                st_d.ctl.pp_dis  = st_q.ctl.pp_dis  | wdata.pp_dis;
            end else begin
                st_d.ctl.dma_dis = wdata.dma_dis;
                st_d.ctl.pp_dis  = wdata.pp_dis;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl.fetch_dis <= rst_dis;
            st_q.ctl.data_dis  <= rst_dis;
            st_q.ctl.dma_dis   <= 1'b0;
            st_q.ctl.pp_dis    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;

    AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_active && st_q.ctl.dma_dis) |=> st_q.ctl.dma_dis) // R5
        else $error("dma disable cleared while active");

    AST_PP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_active && st_q.ctl.pp_dis) |=> st_q.ctl.pp_dis) // R5
        else $error("pp disable cleared while active");

    AST_CTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q.ctl)) // R7
        else $error("control bits moved without a write");

endmodule

// File: rtl/fg_unlock.sv
module fg_unlock (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prot_installed,
    input  logic [31:0] key_a,
    input  logic [31:0] key_b,
    input  logic        pw_valid,
    input  logic [31:0] pw_data,
    input  logic        resume,
    output logic        suspended
);

    typedef enum logic [0:0] {
        UL_IDLE  = 1'b0,
        UL_FIRST = 1'b1
    } ul_e;

    typedef struct packed {
        ul_e  phase;
        logic susp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!prot_installed || resume) begin
            st_d.phase = UL_IDLE;
            st_d.susp  = 1'b0;
        end else if (pw_valid) begin
            unique case (st_q.phase)
                UL_IDLE: begin
                    if (pw_data == key_a) st_d.phase = UL_FIRST;
                end
                UL_FIRST: begin
                    st_d.phase = UL_IDLE;
                    if (pw_data == key_b) st_d.susp = 1'b1;
                end
                default: st_d.phase = UL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= UL_IDLE;
            st_q.susp  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign suspended = st_q.susp;

    AST_SUSP_NEEDS_PW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.susp) |-> $past(pw_valid)) // R6
        else $error("suspend without password write");

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !st_q.susp) // R7
        else $error("resume did not clear suspend");

endmodule

// File: rtl/fg_cfg_lock.sv
module fg_cfg_lock #(
    parameter int unsigned CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_active,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);

    typedef struct packed {
        logic             used;
        logic [CFG_W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (!prot_active || !st_q.used)) begin
            st_d.val  = wdata;
            st_d.used = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.val;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_active && st_q.used && we) |=> (cfg_q == $past(cfg_q))) // R8
        else $error("locked config rewritten");

endmodule

// File: rtl/fg_decide.sv
module fg_decide
    import fg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prot_active,
    input  ctl_t       ctl,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_fetch,
    input  logic [1:0] req_tag,
    output logic       rsp_valid,
    input  logic       rsp_ready,
    output logic       rsp_grant,
    output logic       rsp_err
);

    typedef struct packed {
        logic vld;
        logic err;
    } st_t;

    st_t  st_d, st_q;
    logic deny;
    logic take;

    always_comb begin
        deny = 1'b0;
        if (prot_active) begin
            if (req_fetch && ctl.fetch_dis)  deny = 1'b1;
            if (!req_fetch && ctl.data_dis)  deny = 1'b1;
        end
        if (!req_fetch) begin
            if (tag_e'(req_tag) == TAG_DMA && ctl.dma_dis) deny = 1'b1;
            if (tag_e'(req_tag) == TAG_PP  && ctl.pp_dis)  deny = 1'b1;
        end
    end

    assign req_ready = !st_q.vld || rsp_ready;
    assign take      = req_valid && req_ready;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.vld = 1'b1;
            st_d.err = deny;
        end else if (rsp_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_err   = st_q.vld & st_q.err;
    assign rsp_grant = st_q.vld & ~st_q.err;

    AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid) // R9
        else $error("accepted request lost");

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err))) // R9
        else $error("response dropped or changed under backpressure");

    AST_MASTER_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_fetch && req_tag == 2'd1 && ctl.dma_dis)
        |=> rsp_err) // R4
        else $error("dma data read not refused");

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import fg_pkg::*;
#(
    parameter int unsigned CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_internal,
    input  logic             prot_installed,
    input  logic [31:0]      key_a,
    input  logic [31:0]      key_b,
    input  logic             pw_valid,
    input  logic [31:0]      pw_data,
    input  logic             resume,
    output logic             suspended,
    input  logic             ctl_we,
    input  logic [3:0]       ctl_wdata,
    output logic [3:0]       ctl_q,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_fetch,
    input  logic [1:0]       req_tag,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_grant,
    output logic             rsp_err
);

    logic prot_active;
    ctl_t ctl;

    assign prot_active = prot_installed & ~suspended;

    fg_unlock u_unlock (
        .clk            (clk),
        .rst_n          (rst_n),
        .prot_installed (prot_installed),
        .key_a          (key_a),
        .key_b          (key_b),
        .pw_valid       (pw_valid),
        .pw_data        (pw_data),
        .resume         (resume),
        .suspended      (suspended)
    );

    fg_ctl_reg u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .boot_internal  (boot_internal),
        .prot_installed (prot_installed),
        .prot_active    (prot_active),
        .we             (ctl_we),
        .wdata          (ctl_t'(ctl_wdata)),
        .ctl_q          (ctl)
    );

    assign ctl_q = ctl;

    fg_cfg_lock #(.CFG_W(CFG_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_active (prot_active),
        .we          (cfg_we),
        .wdata       (cfg_wdata),
        .cfg_q       (cfg_q)
    );

    fg_decide u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_active (prot_active),
        .ctl         (ctl),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_fetch   (req_fetch),
        .req_tag     (req_tag),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_grant   (rsp_grant),
        .rsp_err     (rsp_err)
    );

endmodule

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;

    localparam int unsigned CFG_W = 16;
    localparam logic [31:0] KA = 32'hCAFE_0001;
    localparam logic [31:0] KB = 32'h5EED_0002;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             boot_internal = 1'b0;
    logic             prot_installed = 1'b1;
    logic             pw_valid = 1'b0;
    logic [31:0]      pw_data = '0;
    logic             resume = 1'b0;
    logic             suspended;
    logic             ctl_we = 1'b0;
    logic [3:0]       ctl_wdata = '0;
    logic [3:0]       ctl_q;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_q;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_fetch = 1'b0;
    logic [1:0]       req_tag = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b1;
    logic             rsp_grant;
    logic             rsp_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    flash_guard #(.CFG_W(CFG_W)) u_flash_guard (
        .clk(clk), .rst_n(rst_n), .boot_internal(boot_internal),
        .prot_installed(prot_installed), .key_a(KA), .key_b(KB),
        .pw_valid(pw_valid), .pw_data(pw_data), .resume(resume),
        .suspended(suspended), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .req_valid(req_valid), .req_ready(req_ready), .req_fetch(req_fetch),
        .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_grant(rsp_grant), .rsp_err(rsp_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic internal, input logic inst);
        @(negedge clk);
        rst_n = 1'b0;
        boot_internal = internal;
        prot_installed = inst;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [CFG_W-1:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_pw(input logic [31:0] v);
        pw_valid = 1'b1; pw_data = v;
        @(negedge clk);
        pw_valid = 1'b0;
    endtask

    // one access; response sampled at the negedge after the accepting edge
    task automatic access(input string req, input logic fetch, input logic [1:0] tag,
                          input logic exp_err);
        req_valid = 1'b1; req_fetch = fetch; req_tag = tag;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " err"},   {31'd0, rsp_err},   {31'd0, exp_err});
        check({req, " grant"}, {31'd0, rsp_grant}, {31'd0, ~exp_err});
        @(negedge clk);
    endtask

    task automatic t_reset_ext;
        do_reset(1'b0, 1'b1);
        check("R1 ctl reset ext", {28'd0, ctl_q}, 32'h3);
        check("R1 suspended reset", {31'd0, suspended}, 32'd0);
        check("R1 rsp_valid reset", {31'd0, rsp_valid}, 32'd0);
        access("R2 fetch blocked", 1'b1, 2'd0, 1'b1);
        access("R2 data blocked", 1'b0, 2'd0, 1'b1);
    endtask

    task automatic t_data_only;
        wr_ctl(4'b0010);
        access("R2 fetch allowed data-only", 1'b1, 2'd0, 1'b0);
        access("R2 data refused data-only", 1'b0, 2'd0, 1'b1);
    endtask

    task automatic t_master_bits;
        wr_ctl(4'b0000);
        wr_ctl(4'b1100);
        check("R5 set master bits active", {28'd0, ctl_q}, 32'hC);
        access("R4 dma data refused", 1'b0, 2'd1, 1'b1);
        access("R4 pp data refused", 1'b0, 2'd2, 1'b1);
        access("R4 cpu data granted", 1'b0, 2'd0, 1'b0);
        access("R4 dma fetch granted", 1'b1, 2'd1, 1'b0);
        wr_ctl(4'b0010);
        check("R5 clear ignored active", {28'd0, ctl_q}, 32'hE);
    endtask

    task automatic t_password;
        wr_pw(KA); wr_pw(32'h1234_5678);
        check("R6 mismatch keeps active", {31'd0, suspended}, 32'd0);
        wr_pw(KB);
        check("R6 out of order", {31'd0, suspended}, 32'd0);
        wr_pw(KA); wr_pw(KB);
        check("R6 unlock", {31'd0, suspended}, 32'd1);
        access("R3 data granted suspended", 1'b0, 2'd0, 1'b0);
        access("R4 dma still refused suspended", 1'b0, 2'd1, 1'b1);
        wr_ctl(4'b0010);
        check("R5 clear allowed suspended", {28'd0, ctl_q}, 32'h2);
        access("R4 dma granted after clear", 1'b0, 2'd1, 1'b0);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        check("R7 resume clears flag", {31'd0, suspended}, 32'd0);
        check("R7 ctl kept", {28'd0, ctl_q}, 32'h2);
        access("R7 data refused after resume", 1'b0, 2'd0, 1'b1);
    endtask

    task automatic t_cfg;
        do_reset(1'b0, 1'b1);
        wr_cfg(16'h1234);
        check("R8 first write", {16'd0, cfg_q}, 32'h1234);
        wr_cfg(16'h5678);
        check("R8 second ignored", {16'd0, cfg_q}, 32'h1234);
        wr_pw(KA); wr_pw(KB);
        wr_cfg(16'h5678);
        check("R8 write while suspended", {16'd0, cfg_q}, 32'h5678);
    endtask

    task automatic t_uninstalled;
        do_reset(1'b0, 1'b0);
        check("R1 ctl reset uninstalled", {28'd0, ctl_q}, 32'h0);
        wr_ctl(4'b0011);
        access("R3 fetch granted uninstalled", 1'b1, 2'd0, 1'b0);
        access("R3 data granted uninstalled", 1'b0, 2'd0, 1'b0);
        wr_cfg(16'h0A0A); wr_cfg(16'h0B0B);
        check("R8 uninstalled rewrites", {16'd0, cfg_q}, 32'h0B0B);
        wr_pw(KA); wr_pw(KB);
        check("R6 no suspend uninstalled", {31'd0, suspended}, 32'd0);
    endtask

    task automatic t_internal;
        do_reset(1'b1, 1'b1);
        check("R10 ctl reset internal", {28'd0, ctl_q}, 32'h0);
        access("R10 data granted internal", 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_backpressure;
        do_reset(1'b0, 1'b1);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_fetch = 1'b1; req_tag = 2'd0;
        @(negedge clk);
        req_valid = 1'b1; req_fetch = 1'b0;
        check("R9 valid after one cycle", {31'd0, rsp_valid}, 32'd1);
        check("R9 ready low while held", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        check("R9 held valid", {31'd0, rsp_valid}, 32'd1);
        check("R9 held err", {31'd0, rsp_err}, 32'd1);
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R9 released", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        fork
            begin
                t_reset_ext();
                t_data_only();
                t_master_bits();
                t_password();
                t_cfg();
                t_uninstalled();
                t_internal();
                t_backpressure();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule